// File: doc/BRIEF.md
# Conflict-Free Window Read Image Store

This block holds a small two-dimensional pixel image and returns any rectangular window of `WIN_W` by `WIN_H` pixels in a single read. The window may start at any pixel position. Storage is divided into `WIN_W * WIN_H` independent banks. The bank is chosen from the low-order residues of the pixel coordinates, so any window touches each bank exactly once.

The image is loaded one pixel per cycle through a write port addressed by column and row. A read takes the window's top-left corner. From that single origin, every bank gets its own word address. One cycle later the bank outputs are rotated in two dimensions and come out in raster order. A window that runs past the right or bottom image edge is flagged as an error. Its data is then meaningless.

Top module: `winmem_top`

## Requirements
- R1: While reset is held and in the cycle after it, `rd_valid` and `rd_err` are 0.
- R2: For an origin (x0, y0) with x0+WIN_W ≤ IMG_W and y0+WIN_H ≤ IMG_H, the read returns every window pixel at once. Bits `[(r*WIN_W+c)*PIX_W +: PIX_W]` of `rd_win` hold the pixel at column x0+c, row y0+r.
- R3: `rd_valid` is high in exactly the cycles that follow a cycle with `rd_en` high, which gives one cycle of read latency.
- R4: In a cycle that follows a cycle without `rd_en`, `rd_win` keeps its previous value.
- R5: `rd_err` is registered alongside `rd_valid`. It is 1 when the requested origin has x0+WIN_W > IMG_W or y0+WIN_H > IMG_H, and 0 otherwise. It is never 1 while `rd_valid` is 0.
- R6: A read in the same cycle as a write to a pixel inside the window returns the pixel's old value. A read issued in a later cycle returns the new value.
- R7: The last pixel written to each (column, row) is what any later window covering it returns, whatever the window's alignment to the bank grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one pixel this cycle |
| wr_x | input | XW | Write column |
| wr_y | input | YW | Write row |
| wr_pix | input | PIX_W | Write pixel value |
| rd_en | input | 1 | Start a window read |
| rd_x | input | XW | Window origin column |
| rd_y | input | YW | Window origin row |
| rd_valid | output | 1 | Window result present |
| rd_err | output | 1 | Window exceeded image bounds |
| rd_win | output | WIN_W*WIN_H*PIX_W | Window pixels in raster order |

## Verification
On every cycle the assertions check three things: `rd_valid` follows `rd_en` with one cycle of latency, `rd_err` agrees with the bounds of the requested origin, and the window output holds between reads. Only the bench's scenarios can show that the data is correct. It sweeps every origin of the image, so each rotation offset and each bank-address combination is covered. Separate scenarios cover a write and a read in the same cycle, and a pixel overwritten after loading.

// File: rtl/winmem_pkg.sv
// Package: shared helper functions for the window memory.
// Assumes only integer arguments known at elaboration.
package winmem_pkg;
    // Integer ceiling division.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Bit width for a count, never less than one.
    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/winmem_bank.sv
// Module: one storage bank with one write port and one synchronous read port.
// Assumes a read and a write in the same cycle return the old word (read before write).
module winmem_bank #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);
    logic [PIX_W-1:0] mem [DEPTH];

    // Store on write, register the old word on read.
    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
        if (re) rdata <= (int'(raddr) < DEPTH) ? mem[raddr] : '0;
    end
endmodule

// File: rtl/winmem_addr_gen.sv
// Module: turns one window origin into a word address for every bank, and
// flags origins whose window leaves the image. Purely combinational.
// Assumes bank (i, j) holds pixels with x mod WIN_W = i and y mod WIN_H = j.
module winmem_addr_gen
    import winmem_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12,
    parameter int WIN_W = 4,
    parameter int WIN_H = 3,
    parameter int XW    = 4,
    parameter int YW    = 4,
    parameter int AW    = 4
) (
    input  logic [XW-1:0]                 x0,
    input  logic [YW-1:0]                 y0,
    output logic [WIN_W*WIN_H*AW-1:0]     addr,
    output logic                          out_of_range
);
    localparam int COLS_PB = ceil_div(IMG_W, WIN_W);
    localparam int DEPTH   = COLS_PB * ceil_div(IMG_H, WIN_H);

    // Bounds test on the window's far corner.
    always_comb begin
        out_of_range = (int'(x0) + WIN_W > IMG_W) || (int'(y0) + WIN_H > IMG_H);
    end

    for (genvar j = 0; j < WIN_H; j++) begin : g_row
        for (genvar i = 0; i < WIN_W; i++) begin : g_col
            logic [AW-1:0] a;
            // Word index of the one window pixel that lives in bank (i, j).
            always_comb begin
                int dx, dy, col, row, w;
                dx  = (i - (int'(x0) % WIN_W) + WIN_W) % WIN_W;
                dy  = (j - (int'(y0) % WIN_H) + WIN_H) % WIN_H;
                col = (int'(x0) + dx) / WIN_W;
                row = (int'(y0) + dy) / WIN_H;
                w   = row * COLS_PB + col;
                a   = (w < DEPTH) ? AW'(w) : '0;
            end
            assign addr[(j*WIN_W+i)*AW +: AW] = a;
        end
    end
endmodule

// File: rtl/winmem_rotator.sv
// Module: two-dimensional barrel rotation of the bank outputs into raster order.
// Assumes sx, sy are the origin residues captured with the read.
module winmem_rotator #(
    parameter int WIN_W = 4,
    parameter int WIN_H = 3,
    parameter int PIX_W = 8,
    parameter int SXW   = 2,
    parameter int SYW   = 2
) (
    input  logic [SXW-1:0]                sx,
    input  logic [SYW-1:0]                sy,
    input  logic [WIN_W*WIN_H*PIX_W-1:0]  bank_data,
    output logic [WIN_W*WIN_H*PIX_W-1:0]  win
);
    for (genvar r = 0; r < WIN_H; r++) begin : g_r
        for (genvar c = 0; c < WIN_W; c++) begin : g_c
            logic [PIX_W-1:0] sel;
            // Pick the bank holding pixel (x0+c, y0+r).
            always_comb begin
                int bi;
                bi  = ((int'(sx) + c) % WIN_W) + WIN_W * ((int'(sy) + r) % WIN_H);
                sel = bank_data[bi*PIX_W +: PIX_W];
            end
            assign win[(r*WIN_W+c)*PIX_W +: PIX_W] = sel;
        end
    end
endmodule

// File: rtl/winmem_top.sv
// Module: image store returning any WIN_W x WIN_H window in one read.
// Assumes pixels are interleaved over WIN_W*WIN_H banks by coordinate residue;
// reads have one cycle of latency and writes outside the image are dropped.
module winmem_top
    import winmem_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12,
    parameter int WIN_W = 4,
    parameter int WIN_H = 3,
    parameter int PIX_W = 8,
    parameter int XW    = width_of(IMG_W),
    parameter int YW    = width_of(IMG_H)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [XW-1:0]                wr_x,
    input  logic [YW-1:0]                wr_y,
    input  logic [PIX_W-1:0]             wr_pix,
    input  logic                         rd_en,
    input  logic [XW-1:0]                rd_x,
    input  logic [YW-1:0]                rd_y,
    output logic                         rd_valid,
    output logic                         rd_err,
    output logic [WIN_W*WIN_H*PIX_W-1:0] rd_win
);
    localparam int NB      = WIN_W * WIN_H;
    localparam int COLS_PB = ceil_div(IMG_W, WIN_W);
    localparam int DEPTH   = COLS_PB * ceil_div(IMG_H, WIN_H);
    localparam int AW      = width_of(DEPTH);
    localparam int SXW     = width_of(WIN_W);
    localparam int SYW     = width_of(WIN_H);

    logic [NB*AW-1:0]    rd_addr;
    logic [NB*PIX_W-1:0] bank_q;
    logic                range_bad;
    logic [SXW-1:0]      sx_q;
    logic [SYW-1:0]      sy_q;
    logic                wr_ok;
    logic [AW-1:0]       wr_addr;
    int                  wr_bank;

    // Write decode: target bank and word for the incoming pixel.
    always_comb begin
        int w;
        wr_ok   = wr_en && (int'(wr_x) < IMG_W) && (int'(wr_y) < IMG_H);
        wr_bank = (int'(wr_x) % WIN_W) + WIN_W * (int'(wr_y) % WIN_H);
        w       = (int'(wr_y) / WIN_H) * COLS_PB + int'(wr_x) / WIN_W;
        wr_addr = (w < DEPTH) ? AW'(w) : '0;
    end

    winmem_addr_gen #(
        .IMG_W(IMG_W), .IMG_H(IMG_H), .WIN_W(WIN_W), .WIN_H(WIN_H),
        .XW(XW), .YW(YW), .AW(AW)
    ) u_addr (
        .x0(rd_x), .y0(rd_y), .addr(rd_addr), .out_of_range(range_bad)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic we_b;
        assign we_b = wr_ok && (wr_bank == b);
        winmem_bank #(.DEPTH(DEPTH), .AW(AW), .PIX_W(PIX_W)) u_bank (
            .clk(clk), .we(we_b), .waddr(wr_addr), .wdata(wr_pix),
            .re(rd_en), .raddr(rd_addr[b*AW +: AW]),
            .rdata(bank_q[b*PIX_W +: PIX_W])
        );
    end

    // Read pipeline: strobe, bound flag and rotation residues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_err   <= 1'b0;
            sx_q     <= '0;
            sy_q     <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_err <= range_bad;
                sx_q   <= SXW'(int'(rd_x) % WIN_W);
                sy_q   <= SYW'(int'(rd_y) % WIN_H);
            end else begin
                rd_err <= 1'b0;
            end
        end
    end

    winmem_rotator #(
        .WIN_W(WIN_W), .WIN_H(WIN_H), .PIX_W(PIX_W), .SXW(SXW), .SYW(SYW)
    ) u_rot (
        .sx(sx_q), .sy(sy_q), .bank_data(bank_q), .win(rd_win)
    );
endmodule

// File: rtl/winmem_chk.sv
// Module: protocol checker bound to winmem_top.
// Assumes the same parameters as the bound instance.
module winmem_chk #(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12,
    parameter int WIN_W = 4,
    parameter int WIN_H = 3,
    parameter int PIX_W = 8,
    parameter int XW    = 4,
    parameter int YW    = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rd_en,
    input logic [XW-1:0]                rd_x,
    input logic [YW-1:0]                rd_y,
    input logic                         rd_valid,
    input logic                         rd_err,
    input logic [WIN_W*WIN_H*PIX_W-1:0] rd_win
);
    logic req_bad;
    assign req_bad = (int'(rd_x) + WIN_W > IMG_W) || (int'(rd_y) + WIN_H > IMG_H);

    a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r3_no_valid_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    a_r5_err_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && req_bad) |=> rd_err);
    a_r5_no_err_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !req_bad) |=> !rd_err);
    a_r5_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_valid);
    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_win));
endmodule

bind winmem_top winmem_chk #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .WIN_W(WIN_W), .WIN_H(WIN_H),
    .PIX_W(PIX_W), .XW(XW), .YW(YW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_win(rd_win)
);

// File: tb/winmem_top_bench.sv
// Bench: loads a computed image, sweeps every window origin, then checks
// hold, same-cycle write/read ordering and overwrite behaviour.
module winmem_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IMG_W = 16;
    localparam int IMG_H = 12;
    localparam int WIN_W = 4;
    localparam int WIN_H = 3;
    localparam int PIX_W = 8;
    localparam int XW = 4;
    localparam int YW = 4;
    localparam int WV = WIN_W * WIN_H * PIX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [XW-1:0] wr_x = '0;
    logic [YW-1:0] wr_y = '0;
    logic [PIX_W-1:0] wr_pix = '0;
    logic rd_en = 1'b0;
    logic [XW-1:0] rd_x = '0;
    logic [YW-1:0] rd_y = '0;
    logic rd_valid, rd_err;
    logic [WV-1:0] rd_win;

    int n_checks = 0;
    int n_fail = 0;
    logic [PIX_W-1:0] img [IMG_W][IMG_H];

    winmem_top #(.IMG_W(IMG_W), .IMG_H(IMG_H), .WIN_W(WIN_W), .WIN_H(WIN_H),
                 .PIX_W(PIX_W), .XW(XW), .YW(YW)) u_winmem_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
        .wr_pix(wr_pix), .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_win(rd_win)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [WV-1:0] act,
                         input logic [WV-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WV-1:0] expect_win(input int x0, input int y0);
        logic [WV-1:0] v = '0;
        for (int r = 0; r < WIN_H; r++)
            for (int c = 0; c < WIN_W; c++)
                v[(r*WIN_W+c)*PIX_W +: PIX_W] = img[x0+c][y0+r];
        return v;
    endfunction

    // Issue a read at a negedge; outputs are sampled at the following negedge.
    task automatic do_read(input int x, input int y);
        @(negedge clk);
        rd_en = 1'b1; rd_x = XW'(x); rd_y = YW'(y);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input int x, input int y, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_x = XW'(x); wr_y = YW'(y); wr_pix = PIX_W'(v);
        img[x][y] = PIX_W'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [WV-1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", WV'(rd_valid), '0);
        check("R1 err in reset", WV'(rd_err), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", WV'(rd_valid), '0);

        // R7: load the full image
        for (int y = 0; y < IMG_H; y++)
            for (int x = 0; x < IMG_W; x++)
                do_write(x, y, (x * 7 + y * 13 + 5) & 8'hFF);

        // R2, R3, R5, R7: every origin
        for (int y = 0; y < IMG_H; y++) begin
            for (int x = 0; x < IMG_W; x++) begin
                logic bad;
                bad = (x + WIN_W > IMG_W) || (y + WIN_H > IMG_H);
                do_read(x, y);
                check("R3 valid one cycle after read", WV'(rd_valid), WV'(1));
                check("R5 bounds flag", WV'(rd_err), WV'(bad));
                if (!bad) check("R2 window raster order", rd_win, expect_win(x, y));
            end
        end

        // R3: strobe drops when no read; R4: output held
        do_read(5, 2);
        held = rd_win;
        check("R2 window before hold", held, expect_win(5, 2));
        repeat (3) @(negedge clk);
        check("R3 no valid when idle", WV'(rd_valid), '0);
        check("R5 no err when idle", WV'(rd_err), '0);
        check("R4 window held while idle", rd_win, held);

        // R6: write and read in the same cycle
        held = expect_win(4, 3);
        @(negedge clk);
        rd_en = 1'b1; rd_x = 4'd4; rd_y = 4'd3;
        wr_en = 1'b1; wr_x = 4'd5; wr_y = 4'd4; wr_pix = 8'hA5;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        img[5][4] = 8'hA5;
        check("R6 same-cycle read sees old pixel", rd_win, held);
        do_read(4, 3);
        check("R6 later read sees new pixel", rd_win, expect_win(4, 3));

        // R7: overwrite pixel at a corner, read with several alignments
        do_write(11, 8, 8'h3C);
        for (int k = 0; k < WIN_W; k++) begin
            do_read(11 - k, 8 - (k % WIN_H));
            check("R7 overwritten pixel at any alignment", rd_win,
                  expect_win(11 - k, 8 - (k % WIN_H)));
        end

        // R2: back-to-back reads
        @(negedge clk);
        rd_en = 1'b1; rd_x = 4'd0; rd_y = 4'd0;
        @(negedge clk);
        rd_x = 4'd12; rd_y = 4'd9;
        check("R2 back-to-back first", rd_win, expect_win(0, 0));
        @(negedge clk);
        rd_en = 1'b0;
        check("R2 back-to-back second", rd_win, expect_win(12, 9));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule